// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the bus sequences that an 8-bit CPU core uses to enter and leave interrupt handlers. At each instruction boundary, signalled by a one-cycle strobe from the core, it looks at the pending interrupt sources. A latched non-maskable request always wins. A level-sensitive maskable request is taken only when the status register's interrupt-disable bit is clear. Once a request is accepted, the block pushes the program counter and the status byte onto a 256-byte descending stack. It then reads the handler vector and loads the program counter, the status register (with the disable bit set) and the stack pointer through load strobes.

When the core strobes a return request, the block pops the status byte and the program counter from the stack. It then restores them, together with the stack pointer. The busy output is high for the whole sequence, and the core must not fetch an instruction while it is high. The memory port is byte wide. Read data arrives on the cycle after the request.

Top module: `intr_seq`

## Requirements
- R1: Stack bytes live at address 0x0100 plus the 8-bit stack pointer, with the pointer wrapping modulo 256. Entry writes at SP, SP-1 and SP-2 and then loads SP-3 into the stack pointer.
- R2: Entry writes PC[15:8] first, then PC[7:0], then the status byte captured at acceptance, one write per cycle.
- R3: After the pushes, entry reads the vector low byte and then the high byte, from 0xFFFA/0xFFFB for the non-maskable source and from 0xFFFE/0xFFFF for the maskable one. It then loads the program counter with {high, low}.
- R4: When both sources are pending at a boundary, the non-maskable one is serviced.
- R5: The maskable input is level-sensitive and is ignored while status bit 2 (interrupt disable) is set.
- R6: The non-maskable input is rising-edge-triggered and ignores status bit 2. An edge that arrives during a busy sequence stays latched until a later boundary. A level held high is serviced only once.
- R7: On entry, the status load carries the captured status with bit 2 forced to one. It is issued in the cycle after the status byte is written, together with the first vector read.
- R8: On return, the block reads from SP+1 (status), SP+2 (PC low) and SP+3 (PC high). It then loads the status, the program counter and SP+3 in one cycle.
- R9: Interrupts are sampled only in a cycle with the boundary strobe high. A return request is accepted whenever the block is idle and takes precedence over a boundary strobe in the same cycle.
- R10: Busy is high from the cycle after acceptance through the program counter load: 6 cycles for entry and 4 cycles for return. No memory request is made while busy is low.
- R11: After reset, busy, the memory request and all load strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable request, edge-triggered |
| irq_pin | input | 1 | Maskable request, level-sensitive |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| rti_req | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status register |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | Sequence in progress; the core holds off fetch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid on the cycle after a read request |
| pc_load | output | 1 | Load the program counter from pc_out |
| pc_out | output | 16 | New program counter |
| st_load | output | 1 | Load the status register from st_out |
| st_out | output | 8 | New status value |
| sp_load | output | 1 | Load the stack pointer from sp_out |
| sp_out | output | 8 | New stack pointer |

## Verification
The bench goes after the stack wrap at pointer 0x01. A design that forgot the page or the modulo arithmetic would write to page zero or to 0x0200 and would restore the wrong context. Both sources are made pending together, to catch a design that let the maskable vector win. A maskable level is held with the disable bit set, to catch a design that ignored the mask. A non-maskable edge is raised in the middle of a busy sequence and then held high: a design without a latch would lose it, and a design without edge detection would re-enter the handler at every boundary. A maskable level is also held with no boundary strobe, which exposes a design that samples interrupts at any time.

// File: rtl/intr_pkg.sv
package intr_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PSH_HI,
      S_PSH_LO,
      S_PSH_ST,
      S_VEC_LO,
      S_VEC_HI,
      S_VEC_FIN,
      S_POP_ST,
      S_POP_LO,
      S_POP_HI,
      S_RET_FIN
   } seq_state_e;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_NMI,
      SRC_IRQ,
      SRC_RET
   } seq_src_e;

endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_pin,
   input  logic clear,
   output logic pend
);

   logic act;
   logic act_q;

   generate
      if (ACTIVE_LOW) begin : g_pol_lo
         assign act = ~nmi_pin;
      end else begin : g_pol_hi
         assign act = nmi_pin;
      end
   endgenerate

   wire edge_seen = act & ~act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         act_q <= act;
         // a new edge in the clearing cycle is kept
         pend  <= edge_seen | (pend & ~clear);
      end
   end

endmodule

// File: rtl/intr_arb.sv
module intr_arb
   import intr_pkg::*;
#(
   parameter int DW       = 8,
   parameter int IDIS_BIT = 2
) (
   input  logic          idle,
   input  logic          boundary,
   input  logic          ret_req,
   input  logic          nmi_pend,
   input  logic          irq_act,
   input  logic [DW-1:0] status,
   output seq_src_e      grant
);

   wire irq_ok = irq_act & ~status[IDIS_BIT];

   always_comb begin
      grant = SRC_NONE;
      if (idle) begin
         if (ret_req)                    grant = SRC_RET;
         else if (boundary && nmi_pend)  grant = SRC_NMI;
         else if (boundary && irq_ok)    grant = SRC_IRQ;
      end
   end

endmodule

// File: rtl/intr_bus_gen.sv
module intr_bus_gen
   import intr_pkg::*;
#(
   parameter int          AW         = 16,
   parameter int          DW         = 8,
   parameter int          SP_W       = 8,
   parameter int unsigned STACK_PAGE = 1
) (
   input  seq_state_e      state,
   input  logic [SP_W-1:0] sp_q,
   input  logic [AW-1:0]   pc_q,
   input  logic [DW-1:0]   st_q,
   input  logic [AW-1:0]   vec_q,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata
);

   localparam int PAGE_W = AW - SP_W;
   localparam logic [PAGE_W-1:0] PAGE_BITS = PAGE_W'(STACK_PAGE);

   logic [SP_W-1:0] sp_off;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      sp_off    = sp_q;
      mem_wdata = '0;
      mem_addr  = '0;
      unique case (state)
         S_PSH_HI: begin
            mem_req = 1'b1; mem_we = 1'b1;
            sp_off = sp_q;
            mem_wdata = pc_q[AW-1:DW];
         end
         S_PSH_LO: begin
            mem_req = 1'b1; mem_we = 1'b1;
            sp_off = sp_q - SP_W'(1);
            mem_wdata = pc_q[DW-1:0];
         end
         S_PSH_ST: begin
            mem_req = 1'b1; mem_we = 1'b1;
            sp_off = sp_q - SP_W'(2);
            mem_wdata = st_q;
         end
         S_POP_ST: begin
            mem_req = 1'b1;
            sp_off = sp_q + SP_W'(1);
         end
         S_POP_LO: begin
            mem_req = 1'b1;
            sp_off = sp_q + SP_W'(2);
         end
         S_POP_HI: begin
            mem_req = 1'b1;
            sp_off = sp_q + SP_W'(3);
         end
         default: ;
      endcase
      if (state == S_VEC_LO) begin
         mem_req  = 1'b1;
         mem_addr = vec_q;
      end else if (state == S_VEC_HI) begin
         mem_req  = 1'b1;
         mem_addr = vec_q + AW'(1);
      end else begin
         mem_addr = {PAGE_BITS, sp_off};
      end
   end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
   import intr_pkg::*;
#(
   parameter int          AW             = 16,
   parameter int          DW             = 8,
   parameter int          SP_W           = 8,
   parameter int unsigned STACK_PAGE     = 1,
   parameter logic [15:0] NMI_VEC        = 16'hFFFA,
   parameter logic [15:0] IRQ_VEC        = 16'hFFFE,
   parameter int          IDIS_BIT       = 2,
   parameter bit          NMI_ACTIVE_LOW = 1'b0,
   parameter bit          IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nmi_pin,
   input  logic            irq_pin,
   input  logic            insn_done,
   input  logic            rti_req,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   status_in,
   input  logic [SP_W-1:0] sp_in,
   output logic            busy,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            pc_load,
   output logic [AW-1:0]   pc_out,
   output logic            st_load,
   output logic [DW-1:0]   st_out,
   output logic            sp_load,
   output logic [SP_W-1:0] sp_out
);

   localparam int CTX_BYTES = AW / DW + 1;
   localparam logic [DW-1:0] IDIS_MASK = DW'(1) << IDIS_BIT;

   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("program counter must be two data bytes wide");
      end
      if (IDIS_BIT >= DW) begin : g_bad_idis
         $error("interrupt-disable bit outside the status byte");
      end
      if (SP_W >= AW) begin : g_bad_sp
         $error("stack pointer must be narrower than the address");
      end
   endgenerate

   seq_state_e      state_q, state_d;
   seq_src_e        grant;
   logic            nmi_pend;
   logic            irq_act;
   logic [AW-1:0]   pc_q;
   logic [DW-1:0]   st_q;
   logic [DW-1:0]   st_pop_q;
   logic [DW-1:0]   lo_q;
   logic [SP_W-1:0] sp_q;
   logic [AW-1:0]   vec_q;

   generate
      if (IRQ_ACTIVE_LOW) begin : g_irq_lo
         assign irq_act = ~irq_pin;
      end else begin : g_irq_hi
         assign irq_act = irq_pin;
      end
   endgenerate

   wire idle = (state_q == S_IDLE);

   intr_nmi_latch #(.ACTIVE_LOW(NMI_ACTIVE_LOW)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_pin (nmi_pin),
      .clear   (grant == SRC_NMI),
      .pend    (nmi_pend)
   );

   intr_arb #(.DW(DW), .IDIS_BIT(IDIS_BIT)) u_arb (
      .idle     (idle),
      .boundary (insn_done),
      .ret_req  (rti_req),
      .nmi_pend (nmi_pend),
      .irq_act  (irq_act),
      .status   (status_in),
      .grant    (grant)
   );

   intr_bus_gen #(
      .AW(AW), .DW(DW), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE)
   ) u_bus (
      .state     (state_q),
      .sp_q      (sp_q),
      .pc_q      (pc_q),
      .st_q      (st_q),
      .vec_q     (vec_q),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE: begin
            if (grant == SRC_RET)                            state_d = S_POP_ST;
            else if (grant == SRC_NMI || grant == SRC_IRQ)   state_d = S_PSH_HI;
         end
         S_PSH_HI:  state_d = S_PSH_LO;
         S_PSH_LO:  state_d = S_PSH_ST;
         S_PSH_ST:  state_d = S_VEC_LO;
         S_VEC_LO:  state_d = S_VEC_HI;
         S_VEC_HI:  state_d = S_VEC_FIN;
         S_VEC_FIN: state_d = S_IDLE;
         S_POP_ST:  state_d = S_POP_LO;
         S_POP_LO:  state_d = S_POP_HI;
         S_POP_HI:  state_d = S_RET_FIN;
         S_RET_FIN: state_d = S_IDLE;
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         pc_q     <= '0;
         st_q     <= '0;
         sp_q     <= '0;
         vec_q    <= '0;
         lo_q     <= '0;
         st_pop_q <= '0;
      end else begin
         state_q <= state_d;
         if (grant != SRC_NONE) begin
            pc_q  <= pc_in;
            st_q  <= status_in;
            sp_q  <= sp_in;
            vec_q <= (grant == SRC_NMI) ? AW'(NMI_VEC) : AW'(IRQ_VEC);
         end
         if (state_q == S_VEC_HI || state_q == S_POP_HI) lo_q <= mem_rdata;
         if (state_q == S_POP_LO) st_pop_q <= mem_rdata;
      end
   end

   wire entry_fin = (state_q == S_VEC_LO);
   wire ret_fin   = (state_q == S_RET_FIN);

   assign busy    = ~idle;
   assign st_load = entry_fin | ret_fin;
   assign sp_load = entry_fin | ret_fin;
   assign st_out  = entry_fin ? (st_q | IDIS_MASK) : st_pop_q;
   assign sp_out  = entry_fin ? (sp_q - SP_W'(CTX_BYTES)) : (sp_q + SP_W'(CTX_BYTES));
   assign pc_load = (state_q == S_VEC_FIN) | ret_fin;
   assign pc_out  = {mem_rdata, lo_q};

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
   parameter int          AW         = 16,
   parameter int          DW         = 8,
   parameter int          SP_W       = 8,
   parameter int unsigned STACK_PAGE = 1,
   parameter int          IDIS_BIT   = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            insn_done,
   input logic            rti_req,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_we,
   input logic [AW-1:0]   mem_addr,
   input logic            st_load,
   input logic [DW-1:0]   st_out,
   input logic            pc_load
);

   localparam int PAGE_W = AW - SP_W;
   localparam logic [PAGE_W-1:0] PAGE_BITS = PAGE_W'(STACK_PAGE);

   wire wr_now = mem_req & mem_we;
   wire stk_rd = mem_req & ~mem_we & (mem_addr[AW-1:SP_W] == PAGE_BITS);

   p_stack_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_now |-> mem_addr[AW-1:SP_W] == PAGE_BITS);

   p_push_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_now && $past(wr_now) |->
      (mem_addr[SP_W-1:0] + SP_W'(1)) == $past(mem_addr[SP_W-1:0]));

   p_pop_asc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stk_rd && $past(stk_rd) |->
      mem_addr[SP_W-1:0] == ($past(mem_addr[SP_W-1:0]) + SP_W'(1)));

   p_entry_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_load && mem_req |-> st_out[IDIS_BIT]);

   p_start_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_done || rti_req));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !pc_load && !st_load);

   p_load_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);

endmodule

bind intr_seq intr_seq_chk #(
   .AW(AW), .DW(DW), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE), .IDIS_BIT(IDIS_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .insn_done (insn_done),
   .rti_req   (rti_req),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .st_load   (st_load),
   .st_out    (st_out),
   .pc_load   (pc_load)
);

// File: tb/intr_seq_tb.sv
module intr_seq_tb;

   localparam int K_WR = 0, K_RD = 1, K_ST = 2, K_SP = 3, K_PC = 4;

   typedef struct {
      int          kind;
      logic [15:0] addr;
      logic [15:0] data;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi_pin = 1'b0, irq_pin = 1'b0, insn_done = 1'b0, rti_req = 1'b0;
   logic [15:0] pc_r;
   logic [7:0]  st_r, sp_r;
   logic busy, mem_req, mem_we, pc_load, st_load, sp_load;
   logic [15:0] mem_addr, pc_out;
   logic [7:0]  mem_wdata, mem_rdata, st_out, sp_out;

   logic        cfg_go = 1'b0;
   logic [15:0] cfg_pc = '0;
   logic [7:0]  cfg_st = '0, cfg_sp = '0;
   logic [7:0]  stk [256];

   int    n_checks = 0, n_fails = 0;
   bit    done = 1'b0;
   string cur_tag = "R11";
   exp_t  exp_q[$];

   always #2 clk = ~clk;

   intr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
      .insn_done(insn_done), .rti_req(rti_req), .pc_in(pc_r),
      .status_in(st_r), .sp_in(sp_r), .busy(busy), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_out(pc_out),
      .st_load(st_load), .st_out(st_out), .sp_load(sp_load), .sp_out(sp_out)
   );

   function automatic logic [7:0] rd_byte(input logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h12;
         16'hFFFE: return 8'h78;
         16'hFFFF: return 8'h56;
         default:  return (a[15:8] == 8'h01) ? stk[a[7:0]] : 8'hEE;
      endcase
   endfunction

   // core and memory model
   always @(posedge clk) begin
      if (mem_req && mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= rd_byte(mem_addr);
      if (cfg_go) begin
         pc_r <= cfg_pc; st_r <= cfg_st; sp_r <= cfg_sp;
      end else begin
         if (pc_load) pc_r <= pc_out;
         if (st_load) st_r <= st_out;
         if (sp_load) sp_r <= sp_out;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic see(input int kind, input logic [15:0] addr, input logic [15:0] data);
      exp_t e;
      n_checks++;
      if (exp_q.size() == 0) begin
         n_fails++;
         $display("FAIL %s: actual event kind %0d addr %h data %h, expected none",
                  cur_tag, kind, addr, data);
         return;
      end
      e = exp_q.pop_front();
      if (e.kind != kind || ((kind == K_WR || kind == K_RD) && e.addr != addr) ||
          (kind != K_RD && e.data != data)) begin
         n_fails++;
         $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                  e.tag, kind, addr, data, e.kind, e.addr, e.data);
      end
   endtask

   // monitor: outputs depend only on registers, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_req) see(mem_we ? K_WR : K_RD, mem_addr, {8'h00, mem_wdata});
         if (st_load) see(K_ST, 16'h0, {8'h00, st_out});
         if (sp_load) see(K_SP, 16'h0, {8'h00, sp_out});
         if (pc_load) see(K_PC, 16'h0, pc_out);
      end
   end

   task automatic push(input int k, input logic [15:0] a, input logic [15:0] d,
                       input string t);
      exp_t e;
      e.kind = k; e.addr = a; e.data = d; e.tag = t;
      exp_q.push_back(e);
   endtask

   task automatic exp_entry(input bit is_nmi, input logic [15:0] pc,
                            input logic [7:0] st, input logic [7:0] sp);
      logic [15:0] v, hv;
      v  = is_nmi ? 16'hFFFA : 16'hFFFE;
      hv = is_nmi ? 16'h1234 : 16'h5678;
      push(K_WR, {8'h01, sp},         {8'h00, pc[15:8]}, "R1");
      push(K_WR, {8'h01, sp - 8'd1},  {8'h00, pc[7:0]},  "R2");
      push(K_WR, {8'h01, sp - 8'd2},  {8'h00, st},       "R2");
      push(K_RD, v, 16'h0, "R3");
      push(K_ST, 16'h0, {8'h00, st | 8'h04}, "R7");
      push(K_SP, 16'h0, {8'h00, sp - 8'd3},  "R1");
      push(K_RD, v + 16'd1, 16'h0, "R3");
      push(K_PC, 16'h0, hv, is_nmi ? "R4" : "R3");
   endtask

   task automatic exp_ret(input logic [15:0] pc, input logic [7:0] st,
                          input logic [7:0] sp);
      push(K_RD, {8'h01, sp + 8'd1}, 16'h0, "R8");
      push(K_RD, {8'h01, sp + 8'd2}, 16'h0, "R8");
      push(K_RD, {8'h01, sp + 8'd3}, 16'h0, "R8");
      push(K_ST, 16'h0, {8'h00, st},        "R8");
      push(K_SP, 16'h0, {8'h00, sp + 8'd3}, "R8");
      push(K_PC, 16'h0, pc,                 "R8");
   endtask

   task automatic cfg(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp);
      @(negedge clk);
      cfg_pc = pc; cfg_st = st; cfg_sp = sp; cfg_go = 1'b1;
      @(negedge clk);
      cfg_go = 1'b0;
   endtask

   // one strobe, then count busy cycles
   task automatic fire(input bit bnd, input bit ret, input bit nmi_mid,
                       input int exp_busy, input string tag);
      int n;
      @(negedge clk);
      insn_done = bnd; rti_req = ret;
      @(negedge clk);
      insn_done = 1'b0; rti_req = 1'b0;
      if (nmi_mid) nmi_pin = 1'b1;
      n = 0;
      while (busy && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(n == exp_busy, {tag, " busy length"}, 16'(n), 16'(exp_busy));
      chk(exp_q.size() == 0, {tag, " events left"}, 16'(exp_q.size()), 16'h0);
      exp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) stk[i] = 8'h00;
      pc_r = '0; st_r = '0; sp_r = '0; mem_rdata = '0;
      repeat (4) @(negedge clk);
      // R11: reset state
      chk(busy == 1'b0,    "R11 busy",    {15'h0, busy},    16'h0);
      chk(mem_req == 1'b0, "R11 mem_req", {15'h0, mem_req}, 16'h0);
      chk(!pc_load && !st_load && !sp_load, "R11 loads", {13'h0, pc_load, st_load, sp_load}, 16'h0);
      rst_n = 1'b1;

      // maskable entry then return (R1 R2 R3 R7 R10 R8)
      cfg(16'h8123, 8'h20, 8'hFD);
      irq_pin = 1'b1;
      cur_tag = "R10";
      exp_entry(1'b0, 16'h8123, 8'h20, 8'hFD);
      fire(1'b1, 1'b0, 1'b0, 6, "R10");
      irq_pin = 1'b0;
      exp_ret(16'h8123, 8'h20, 8'hFA);
      fire(1'b0, 1'b1, 1'b0, 4, "R8");
      chk(pc_r == 16'h8123, "R8 pc restored", pc_r, 16'h8123);
      chk(sp_r == 8'hFD, "R8 sp restored", {8'h0, sp_r}, 16'h00FD);

      // R5: masked level ignored
      cfg(16'h8200, 8'h24, 8'hFD);
      irq_pin = 1'b1;
      cur_tag = "R5";
      fire(1'b1, 1'b0, 1'b0, 0, "R5");
      irq_pin = 1'b0;

      // R9: no boundary, no service
      cfg(16'h8300, 8'h20, 8'hFD);
      irq_pin = 1'b1;
      cur_tag = "R9";
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R9 idle without strobe", {15'h0, busy}, 16'h0);
      exp_entry(1'b0, 16'h8300, 8'h20, 8'hFD);
      fire(1'b1, 1'b0, 1'b0, 6, "R9");
      irq_pin = 1'b0;
      exp_ret(16'h8300, 8'h20, 8'hFA);
      fire(1'b0, 1'b1, 1'b0, 4, "R8");

      // R4: both pending, non-maskable wins
      cfg(16'h4000, 8'h20, 8'hFF);
      @(negedge clk) nmi_pin = 1'b1;
      @(negedge clk) nmi_pin = 1'b0;
      irq_pin = 1'b1;
      cur_tag = "R4";
      exp_entry(1'b1, 16'h4000, 8'h20, 8'hFF);
      fire(1'b1, 1'b0, 1'b0, 6, "R4");
      irq_pin = 1'b0;
      exp_ret(16'h4000, 8'h20, 8'hFC);
      fire(1'b0, 1'b1, 1'b0, 4, "R8");

      // R6: edge during busy is latched, ignores mask, held level serviced once
      cfg(16'h9000, 8'h20, 8'hF0);
      irq_pin = 1'b1;
      cur_tag = "R6";
      exp_entry(1'b0, 16'h9000, 8'h20, 8'hF0);
      fire(1'b1, 1'b0, 1'b1, 6, "R6");
      irq_pin = 1'b0;
      exp_entry(1'b1, 16'h5678, 8'h24, 8'hED);
      fire(1'b1, 1'b0, 1'b0, 6, "R6");
      chk(pc_r == 16'h1234, "R6 handler", pc_r, 16'h1234);
      fire(1'b1, 1'b0, 1'b0, 0, "R6 held");
      nmi_pin = 1'b0;

      // R1: stack pointer wrap
      cfg(16'hABCD, 8'hC3, 8'h01);
      irq_pin = 1'b1;
      cur_tag = "R1";
      exp_entry(1'b0, 16'hABCD, 8'hC3, 8'h01);
      fire(1'b1, 1'b0, 1'b0, 6, "R1");
      irq_pin = 1'b0;
      exp_ret(16'hABCD, 8'hC3, 8'hFE);
      fire(1'b0, 1'b1, 1'b0, 4, "R8");
      chk(st_r == 8'hC3, "R8 status restored", {8'h0, st_r}, 16'h00C3);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule